// File: doc/BRIEF.md
# Pipelined Converter Code Correction

This block sits behind a seven-stage pipelined analog-to-digital converter and turns the stages' raw 2-bit decisions into one corrected 8-bit sample per conversion. Stage 0 converts a sample first. Each later stage converts the residue of that same sample one enabled cycle after the stage before it. The block therefore delays every stage's code by its own number of cycles, so that all seven codes of one sample arrive at the adder together.

Stage 0 is the coarse stage and contributes two bits of weight. Stages 1 to 5 are redundant stages, and the last stage is a flash stage. Each stage's code is added one bit position below the previous stage's code, with a one-bit overlap. This overlap absorbs comparator offsets, so the output never skips a code. A sum above 255 is clamped instead of wrapping.

The input side is a sampling stream with no back-pressure. `en` acts as the upstream valid: each cycle with `en` high delivers one set of stage codes and advances every register in the block. A cycle with `en` low freezes the block. The result stream has no ready input because a converter cannot pause its sampling. A downstream consumer takes `sample` on each enabled cycle while `sample_valid` is high.

Top module: `adc_corr`

## Requirements
- R1: While `rst_n` is low, `sample` is 0 and both `sample_valid` and `code_err` are 0.
- R2: `sample_valid` rises at the 7th rising edge with `en` high after reset is released. It then stays high until the next reset.
- R3: When `en` is low, no internal state changes. `sample`, `sample_valid` and `code_err` keep their values, and the stage codes presented in that cycle have no effect on any later output.
- R4: Stage i of a sample is presented on `stage_codes[2i+1:2i]`, i enabled cycles after that sample's stage 0 code. The sample's result appears on `sample` after the enabled edge at which its stage 6 code is presented.
- R5: The result equals the sum over i = 0..6 of code_i × 2^(6−i), with each code read as an unsigned 2-bit value. Different code combinations with the same sum, such as a redundant 2 in place of a carry, give the same output.
- R6: When that sum exceeds 255, `sample` is 255.
- R7: For stages 1 to 5, the code 2'b11 is illegal and is weighted as 2'b10. For stages 0 and 6, 2'b11 is a legal value of 3.
- R8: `code_err` goes high after any enabled edge at which stages 1 to 5 present 2'b11, and it stays high until reset. A code of 3 on stage 0 or stage 6 never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable / input valid; low freezes the block |
| stage_codes | input | 14 | Stage i code in bits [2i+1:2i] |
| sample | output | 8 | Corrected, clamped result |
| sample_valid | output | 1 | High once the pipeline has filled |
| code_err | output | 1 | Sticky flag for an illegal redundant-stage code |

## Verification
The embedded properties check the following on every cycle:
- every output is frozen when `en` is low;
- each delay line shifts only on an enabled edge;
- the valid flag, once set, stays set;
- the error flag sets on an illegal code and stays set;
- an over-range sum produces 255.

The correct arithmetic value, the per-stage alignment across cycles, and the exact fill latency can only be shown by the bench's scenarios. They compare each emitted sample against a reference sum built from codes that were spread over seven enabled cycles and interleaved with frozen cycles that carry illegal garbage.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  // Bit position at which a stage's code is added (one bit of overlap
  // between neighbours for a 2-bit code).
  function automatic int unsigned stage_shift(input int unsigned idx,
                                              input int unsigned nstg,
                                              input int unsigned cw);
    return (nstg - 1 - idx) * (cw - 1);
  endfunction

  // A stage is redundant when it is neither the coarse first one nor the flash last one.
  function automatic bit is_redundant(input int unsigned idx, input int unsigned nstg);
    return (idx > 0) && (idx < nstg - 1);
  endfunction

endpackage

// File: rtl/adc_corr_guard.sv
module adc_corr_guard
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTG = 7,
  parameter int unsigned CW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NSTG*CW-1:0]   raw_codes,
  output logic [NSTG*CW-1:0]   clean_codes,
  output logic                 code_err
);

  localparam logic [CW-1:0] TOP_CODE  = '1;
  localparam logic [CW-1:0] SUBST     = {{(CW-1){1'b1}}, 1'b0};

  logic [NSTG-1:0] illegal;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    if (is_redundant(g, NSTG)) begin : g_red
      assign illegal[g] = (raw_codes[g*CW +: CW] == TOP_CODE);
      assign clean_codes[g*CW +: CW] = illegal[g] ? SUBST : raw_codes[g*CW +: CW];
    end else begin : g_full
      assign illegal[g] = 1'b0;
      assign clean_codes[g*CW +: CW] = raw_codes[g*CW +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 code_err <= 1'b0;
    else if (en && |illegal)    code_err <= 1'b1;
  end

  // R8: the flag never clears on its own
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

  // R8: an enabled illegal redundant code raises the flag
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && |illegal) |=> code_err);

endmodule

// File: rtl/adc_corr_align.sv
module adc_corr_align
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTG = 7,
  parameter int unsigned CW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NSTG*CW-1:0]   in_codes,
  output logic [NSTG*CW-1:0]   aligned_codes
);

  for (genvar g = 0; g < NSTG; g++) begin : g_lane
    localparam int unsigned DEPTH = NSTG - 1 - g;
    if (DEPTH == 0) begin : g_pass
      assign aligned_codes[g*CW +: CW] = in_codes[g*CW +: CW];
    end else begin : g_dly
      logic [CW-1:0] sr [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int j = 0; j < int'(DEPTH); j++) sr[j] <= '0;
        end else if (en) begin
          sr[0] <= in_codes[g*CW +: CW];
          for (int j = 1; j < int'(DEPTH); j++) sr[j] <= sr[j-1];
        end
      end

      assign aligned_codes[g*CW +: CW] = sr[DEPTH-1];

      // R3: a frozen cycle leaves the lane output unchanged
      p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sr[DEPTH-1]));

      // R4: an enabled edge captures the incoming stage code
      p_lane_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (sr[0] == $past(in_codes[g*CW +: CW])));
    end
  end

endmodule

// File: rtl/adc_corr_sum.sv
module adc_corr_sum
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTG = 7,
  parameter int unsigned CW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NSTG*CW-1:0]   aligned_codes,
  output logic [(NSTG-1)*(CW-1)+CW-1:0] sample
);

  localparam int unsigned OUT_W = (NSTG - 1) * (CW - 1) + CW;
  localparam int unsigned SUM_W = OUT_W + 2;
  localparam logic [OUT_W-1:0] OUT_MAX = '1;

  logic [SUM_W-1:0] acc;
  logic             over;

  always_comb begin
    acc = '0;
    for (int unsigned i = 0; i < NSTG; i++) begin
      acc = acc + (SUM_W'(aligned_codes[i*CW +: CW]) << stage_shift(i, NSTG, CW));
    end
  end

  assign over = (acc > SUM_W'(OUT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sample <= '0;
    else if (en) sample <= over ? OUT_MAX : acc[OUT_W-1:0];
  end

  // R6: an over-range sum saturates instead of wrapping
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && over) |=> (sample == OUT_MAX));

endmodule

// File: rtl/adc_corr_fill.sv
module adc_corr_fill #(
  parameter int unsigned NSTG = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sample_valid
);

  localparam int unsigned CNT_W = $clog2(NSTG + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NSTG);

  logic [CNT_W-1:0] fill_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fill_cnt <= '0;
    else if (en && fill_cnt != FULL) fill_cnt <= fill_cnt + 1'b1;
  end

  assign sample_valid = (fill_cnt == FULL);

  // R2: once full, valid stays high
  p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> sample_valid);

  // R2: valid can only rise on an enabled edge
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_valid) |-> $past(en));

endmodule

// File: rtl/adc_corr.sv
module adc_corr
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTG = 7,
  parameter int unsigned CW   = 2,
  localparam int unsigned OUT_W = (NSTG - 1) * (CW - 1) + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NSTG*CW-1:0]   stage_codes,
  output logic [OUT_W-1:0]     sample,
  output logic                 sample_valid,
  output logic                 code_err
);

  logic [NSTG*CW-1:0] clean_codes;
  logic [NSTG*CW-1:0] aligned_codes;

  adc_corr_guard #(.NSTG(NSTG), .CW(CW)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .raw_codes   (stage_codes),
    .clean_codes (clean_codes),
    .code_err    (code_err)
  );

  adc_corr_align #(.NSTG(NSTG), .CW(CW)) u_align (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .in_codes      (clean_codes),
    .aligned_codes (aligned_codes)
  );

  adc_corr_sum #(.NSTG(NSTG), .CW(CW)) u_sum (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .aligned_codes (aligned_codes),
    .sample        (sample)
  );

  adc_corr_fill #(.NSTG(NSTG)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .sample_valid (sample_valid)
  );

  // R3: a frozen cycle changes no output
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sample) && $stable(sample_valid) && $stable(code_err)));

endmodule

// File: tb/tb_adc_corr.sv
module tb_adc_corr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [13:0] codes = '0;
  logic [7:0]  sample;
  logic        sample_valid;
  logic        code_err;

  adc_corr dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .stage_codes  (codes),
    .sample       (sample),
    .sample_valid (sample_valid),
    .code_err     (code_err)
  );

  always #2 clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  bit          in_reset = 1'b1;
  bit          done = 1'b0;
  bit          exp_err = 1'b0;
  int          n_en = 0;
  logic [13:0] hist [0:6];
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic [7:0]  last_sample = '0;
  logic        last_valid = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input int c0, input int c1, input int c2, input int c3,
                                     input int c4, input int c5, input int c6);
    return {c6[1:0], c5[1:0], c4[1:0], c3[1:0], c2[1:0], c1[1:0], c0[1:0]};
  endfunction

  // Reference: weighted overlap sum with illegal-code substitution and clamp
  function automatic logic [7:0] model(input logic [13:0] v);
    int s = 0;
    for (int i = 0; i < 7; i++) begin
      int c = int'(v[2*i +: 2]);
      if (i >= 1 && i <= 5 && c == 3) c = 2;
      s += c << (6 - i);
    end
    return (s > 255) ? 8'd255 : s[7:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    in_reset = 1'b1;
    rst_n = 1'b0;
    en = 1'b0;
    codes = '0;
    repeat (2) @(negedge clk);
    check(sample == 8'd0, "R1", int'(sample), 0);
    check(sample_valid == 1'b0, "R1", int'(sample_valid), 0);
    check(code_err == 1'b0, "R1", int'(code_err), 0);
    for (int k = 0; k < 7; k++) hist[k] = '0;
    n_en = 0;
    exp_err = 1'b0;
    exp_q.delete();
    tag_q.delete();
    last_sample = '0;
    last_valid = 1'b0;
    rst_n = 1'b1;
    in_reset = 1'b0;
  endtask

  // Driver: launch one new sample and present each stage of the in-flight samples
  task automatic step(input logic [13:0] v, input string tag);
    @(negedge clk);
    for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    for (int i = 0; i < 7; i++) codes[2*i +: 2] = hist[i][2*i +: 2];
    en = 1'b1;
    for (int i = 1; i <= 5; i++) if (codes[2*i +: 2] == 2'b11) exp_err = 1'b1;
    if (n_en >= 6) begin
      exp_q.push_back(model(hist[6]));
      tag_q.push_back(tag);
    end
    n_en++;
  endtask

  task automatic idle(input logic [13:0] garbage);
    @(negedge clk);
    en = 1'b0;
    codes = garbage;
  endtask

  // Monitor: compare one time unit after each rising edge
  always @(posedge clk) begin
    logic e;
    e = en;
    #1;
    if (!in_reset && rst_n) begin
      if (e) begin
        check(sample_valid == (n_en >= 7), "R2", int'(sample_valid), int'(n_en >= 7));
        if (sample_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4", int'(sample), -1);
          end else begin
            logic [7:0] x;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            check(sample == x, t, int'(sample), int'(x));
          end
        end
      end else begin
        check(sample == last_sample, "R3", int'(sample), int'(last_sample));
        check(sample_valid == last_valid, "R3", int'(sample_valid), int'(last_valid));
      end
      check(code_err == exp_err, "R8", int'(code_err), int'(exp_err));
      last_sample = sample;
      last_valid = sample_valid;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 7; k++) hist[k] = '0;
    do_reset();

    // Fill with frozen gaps carrying illegal garbage (R2, R3)
    step(mk(0,0,0,0,0,0,0), "R5");
    step(mk(1,0,0,0,0,0,0), "R5");
    idle(mk(3,3,3,3,3,3,3));
    idle(mk(2,3,1,3,0,3,2));
    step(mk(0,2,2,0,0,0,0), "R5");
    step(mk(1,1,1,1,1,1,1), "R5");
    step(mk(0,2,2,2,2,2,3), "R5");
    idle(mk(1,3,3,0,0,0,0));
    step(mk(3,0,0,0,0,0,3), "R7");
    step(mk(3,2,2,2,2,2,3), "R6");
    step(mk(2,2,2,2,2,2,3), "R6");
    step(mk(3,2,0,0,0,0,1), "R6");
    step(mk(0,0,0,0,0,0,3), "R4");

    // Random legal codes, with occasional frozen cycles
    for (int r = 0; r < 60; r++) begin
      step(mk($urandom_range(0,3), $urandom_range(0,2), $urandom_range(0,2),
              $urandom_range(0,2), $urandom_range(0,2), $urandom_range(0,2),
              $urandom_range(0,3)), "R4");
      if (r % 7 == 3) idle(mk(3,3,3,3,3,3,3));
    end

    // Illegal code on a redundant stage: substituted and flagged (R7, R8)
    step(mk(0,0,3,0,0,0,0), "R7");
    step(mk(0,3,3,3,3,3,0), "R7");
    step(mk(3,3,3,3,3,3,3), "R6");
    for (int r = 0; r < 8; r++) step(mk(1,2,0,1,2,0,2), "R5");

    // Second reset clears the sticky flag and the fill state
    do_reset();
    step(mk(2,1,0,2,1,0,1), "R5");
    idle(mk(0,3,0,0,0,0,0));
    for (int r = 0; r < 9; r++) step(mk(r % 4, 1, 2, 0, 1, 2, 3 - (r % 4)), "R5");
    idle('0);
    idle('0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule